// File: doc/BRIEF.md
# Laser Emitter Enable Gate

This block is the control logic that decides whether a multi-channel laser transmitter may emit light. It takes two enables of opposite polarity, an active-low kill request, a supply-good flag and one fault flag per channel. From these it drives a single global `laser_on_o` and a `ctrl_up_o` status. The light may only come on when both enables agree, no kill is requested, the supply has been good for a programmed hold-off time, and no channel reports a fault. `ctrl_up_o` reports whether the controller itself is up. It ignores the enables and drops on a kill, a fault, or a supply that is not ready.

All control inputs are asynchronous. Each passes through a two-flop synchroniser before use. Timing limits are cycle counts on `clk`. A kill pulse that is shorter than the minimum width is stretched internally to that width. A latched fault clears by itself once the fault flag drops, and no new kill pulse is needed. There is no data stream here, so every pin is plain control or status with no handshake.

Tie-off convention for unconnected inputs: the active-high enable goes to 1, the active-low enable goes to 0, and the kill input goes to 0 (laser off). The synchroniser flops reset to these same safe levels.

Top module: `emitter_gate`

## Requirements
- R1: `laser_on_o` is 1 only when `en_hi_i`=1, `en_lo_n_i`=0, `kill_n_i`=1, the supply is ready and no bit of `fault_i` is set; any other enable combination gives 0.
- R2: A change on `en_hi_i`, `en_lo_n_i` or `kill_n_i` reaches the outputs on the third rising edge after the input is set up; in particular a low on `kill_n_i` forces both outputs to 0 within three cycles.
- R3: `ctrl_up_o` is 1 exactly when the supply is ready, no kill is active and no fault is latched; it does not depend on the two enables, and `laser_on_o` is never 1 while `ctrl_up_o` is 0.
- R4: After `supply_ok_i` rises and stays high, both outputs stay 0 for `HOLDOFF_CYC` cycles after the synchronised flag rises (first high on the edge HOLDOFF_CYC+3 after set-up); a low on `supply_ok_i` forces both outputs to 0 on the fourth edge and restarts the count.
- R5: Any low pulse on `kill_n_i`, however short, keeps both outputs at 0 for at least `MIN_LOW_CYC` cycles; a pulse longer than that ends three edges after `kill_n_i` returns high.
- R6: A set bit in `fault_i` drops both outputs on the fourth edge after set-up; when all bits are clear, the outputs recover on the fourth edge with no kill pulse.
- R7: While `arst_n` is low, and until the supply is ready, both outputs are 0.
- R8: Every one of the `NCH` fault bits acts alone; the lowest and the highest channel each suffice to drop the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| en_hi_i | input | 1 | Enable, active high (tie 1 if unused) |
| en_lo_n_i | input | 1 | Enable, active low (tie 0 if unused) |
| kill_n_i | input | 1 | Kill request, active low; low switches every emitter off |
| supply_ok_i | input | 1 | Supply has reached its minimum operating level |
| fault_i | input | NCH | Per-channel fault flags, 1 = fault |
| laser_on_o | output | 1 | Global emitter enable |
| ctrl_up_o | output | 1 | Controller up status |

## Verification
A kill-stretch counter that reloads wrongly or never reaches zero shows at the ports as a `ctrl_up_o` low period that is too short or never ends. The bench counts that period edge by edge from the start of a one-cycle pulse, so an error shows within `MIN_LOW_CYC`+3 cycles. A hold-off counter stuck off by one moves the first high on `ctrl_up_o` by one edge, and the bench checks the edge before and the edge after. A fault latch that fails to clear leaves both outputs low on the fourth edge after the flags drop. An enable decode with the wrong polarity shows on the first vector that differs.

// File: rtl/eg_pkg.sv
package eg_pkg;
  // Synchronised control inputs, one bit each
  typedef struct packed {
    logic en_hi;
    logic en_lo_n;
    logic kill_n;
    logic sup_ok;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Safe reset levels: enables in their tie-off state, kill asserted, no supply
  localparam ctl_t CTL_SAFE = '{en_hi: 1'b1, en_lo_n: 1'b0, kill_n: 1'b0, sup_ok: 1'b0};
endpackage

// File: rtl/eg_sync.sv
module eg_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/eg_supply_holdoff.sv
module eg_supply_holdoff #(
  parameter int HOLDOFF_CYC = 1000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sup_s,
  output logic ready_o
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             cnt <= '0;
    else if (!sup_s)         cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign ready_o = (cnt == LIMIT);

  AST_READY_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!arst_n)
    ready_o |-> $past(sup_s)); // R4
endmodule

// File: rtl/eg_pulse_stretch.sv
module eg_pulse_stretch #(
  parameter int MIN_LOW_CYC = 2000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic kill_n_s,
  output logic active_o
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(MIN_LOW_CYC - 1);
  localparam logic [CW-1:0] FULL   = CW'(MIN_LOW_CYC);

  logic          kill_prev;
  logic [CW-1:0] remain;
  logic          fall;

  assign fall = kill_prev & ~kill_n_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      kill_prev <= 1'b1;
      remain    <= '0;
    end else begin
      kill_prev <= kill_n_s;
      if (fall)              remain <= RELOAD;
      else if (remain != '0) remain <= remain - 1'b1;
    end
  end

  assign active_o = ~kill_n_s | (remain != '0);

  // Checker: length of each active period, saturating at the minimum
  logic [CW-1:0] act_len;
  logic          active_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      act_len  <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_o;
      if (!active_o)            act_len <= '0;
      else if (act_len != FULL) act_len <= act_len + 1'b1;
    end
  end

  AST_MIN_KILL_WIDTH: assert property (@(posedge clk) disable iff (!arst_n)
    (active_q && !active_o) |-> (act_len == FULL)); // R5
endmodule

// File: rtl/eg_fault_hold.sv
module eg_fault_hold #(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic [NCH-1:0] flt_s,
  output logic           any_o
);
  logic [NCH-1:0] held;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       held[c] <= 1'b0;
      else if (flt_s[c]) held[c] <= 1'b1;
      else               held[c] <= 1'b0;
    end
  end

  assign any_o = |held;
endmodule

// File: rtl/emitter_gate.sv
module emitter_gate
  import eg_pkg::*;
#(
  parameter int NCH         = 12,
  parameter int HOLDOFF_CYC = 1000,
  parameter int MIN_LOW_CYC = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           en_hi_i,
  input  logic           en_lo_n_i,
  input  logic           kill_n_i,
  input  logic           supply_ok_i,
  input  logic [NCH-1:0] fault_i,
  output logic           laser_on_o,
  output logic           ctrl_up_o
);
  ctl_t           ctl_raw, ctl_s;
  logic [NCH-1:0] flt_s;
  logic           kill_act, pwr_rdy, flt_any, up_d, on_d;

  assign ctl_raw = '{en_hi: en_hi_i, en_lo_n: en_lo_n_i, kill_n: kill_n_i, sup_ok: supply_ok_i};

  eg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_SAFE)) u_sync_ctl (
    .clk(clk), .arst_n(arst_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  eg_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_flt (
    .clk(clk), .arst_n(arst_n), .d_i(fault_i), .q_o(flt_s)
  );

  eg_supply_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_hold (
    .clk(clk), .arst_n(arst_n), .sup_s(ctl_s.sup_ok), .ready_o(pwr_rdy)
  );

  eg_pulse_stretch #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_kill (
    .clk(clk), .arst_n(arst_n), .kill_n_s(ctl_s.kill_n), .active_o(kill_act)
  );

  eg_fault_hold #(.NCH(NCH)) u_flt (
    .clk(clk), .arst_n(arst_n), .flt_s(flt_s), .any_o(flt_any)
  );

  assign up_d = pwr_rdy & ~kill_act & ~flt_any;
  assign on_d = up_d & ctl_s.en_hi & ~ctl_s.en_lo_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      laser_on_o <= 1'b0;
      ctrl_up_o  <= 1'b0;
    end else begin
      laser_on_o <= on_d;
      ctrl_up_o  <= up_d;
    end
  end

  logic en_hi_s, en_lo_n_s, kill_n_s;
  assign en_hi_s   = ctl_s.en_hi;
  assign en_lo_n_s = ctl_s.en_lo_n;
  assign kill_n_s  = ctl_s.kill_n;

  AST_BOTH_ENABLES: assert property (@(posedge clk) disable iff (!arst_n)
    laser_on_o |-> $past(en_hi_s && !en_lo_n_s)); // R1
  AST_ON_NEEDS_UP: assert property (@(posedge clk) disable iff (!arst_n)
    laser_on_o |-> ctrl_up_o); // R3
  AST_KILL_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    !kill_n_s |=> (!laser_on_o && !ctrl_up_o)); // R2
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    flt_any |=> (!laser_on_o && !ctrl_up_o)); // R6
  AST_HOLDOFF_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    !pwr_rdy |=> !ctrl_up_o); // R4
endmodule

// File: tb/emitter_gate_test.sv
module emitter_gate_test;
  localparam int NCH  = 12;
  localparam int HOLD = 40;
  localparam int MINL = 30;

  logic clk = 1'b0;
  logic arst_n, en_hi, en_lo_n, kill_n, sup_ok;
  logic [NCH-1:0] fault;
  logic laser_on, ctrl_up;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  emitter_gate #(.NCH(NCH), .HOLDOFF_CYC(HOLD), .MIN_LOW_CYC(MINL)) uut (
    .clk(clk), .arst_n(arst_n), .en_hi_i(en_hi), .en_lo_n_i(en_lo_n),
    .kill_n_i(kill_n), .supply_ok_i(sup_ok), .fault_i(fault),
    .laser_on_o(laser_on), .ctrl_up_o(ctrl_up)
  );

  // {en_hi, en_lo_n, fault[11:0], exp_on, exp_up}; supply ready, kill released
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 1'b0, 12'h000, 1'b1, 1'b1},   // R1 both enables active
    {1'b0, 1'b0, 12'h000, 1'b0, 1'b1},   // R1 R3 high enable off
    {1'b1, 1'b1, 12'h000, 1'b0, 1'b1},   // R1 R3 low enable off
    {1'b0, 1'b1, 12'h000, 1'b0, 1'b1},   // R1 R3 both off
    {1'b1, 1'b0, 12'h001, 1'b0, 1'b0},   // R8 lowest channel
    {1'b1, 1'b0, 12'h800, 1'b0, 1'b0},   // R8 highest channel
    {1'b0, 1'b1, 12'h020, 1'b0, 1'b0},   // R6 fault with enables off
    {1'b1, 1'b0, 12'h000, 1'b1, 1'b1}    // R6 recovery without kill
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0; kill_n = 1'b1;
    sup_ok = 1'b0; fault = '0;
    step(3);
    chk("R7 reset on", laser_on, 1'b0);
    chk("R7 reset up", ctrl_up, 1'b0);
    arst_n = 1'b1;
    step(3);
    chk("R7 no supply up", ctrl_up, 1'b0);

    // R4 power-on hold-off
    sup_ok = 1'b1;
    step(HOLD + 2);
    chk("R4 holdoff edge before", ctrl_up, 1'b0);
    step(1);
    chk("R4 holdoff up", ctrl_up, 1'b1);
    chk("R4 holdoff on", laser_on, 1'b1);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      en_hi   = VEC[i][15];
      en_lo_n = VEC[i][14];
      fault   = VEC[i][13:2];
      step(6);
      chk($sformatf("R1 vec%0d on", i), laser_on, VEC[i][1]);
      chk($sformatf("R3 vec%0d up", i), ctrl_up, VEC[i][0]);
    end

    // R2 enable latency
    en_hi = 1'b0;
    step(2);
    chk("R2 enable edge 2", laser_on, 1'b1);
    step(1);
    chk("R2 enable edge 3", laser_on, 1'b0);
    en_hi = 1'b1;
    step(6);

    // R6 fault latency and self clearing
    fault = 12'h020;
    step(3);
    chk("R6 fault edge 3", ctrl_up, 1'b1);
    step(1);
    chk("R6 fault edge 4", ctrl_up, 1'b0);
    fault = '0;
    step(3);
    chk("R6 clear edge 3", ctrl_up, 1'b0);
    step(1);
    chk("R6 clear edge 4", ctrl_up, 1'b1);
    chk("R6 clear on", laser_on, 1'b1);

    // R2 R5 one-cycle kill pulse
    kill_n = 1'b0;
    step(1);
    kill_n = 1'b1;
    step(2);
    chk("R2 kill off on", laser_on, 1'b0);
    chk("R2 kill off up", ctrl_up, 1'b0);
    step(MINL - 1);
    chk("R5 stretched low", ctrl_up, 1'b0);
    step(1);
    chk("R5 stretch end", ctrl_up, 1'b1);
    chk("R5 stretch end on", laser_on, 1'b1);

    // R5 long kill pulse ends with the input
    kill_n = 1'b0;
    step(MINL + 10);
    chk("R5 long low", laser_on, 1'b0);
    kill_n = 1'b1;
    step(2);
    chk("R5 release edge 2", ctrl_up, 1'b0);
    step(1);
    chk("R5 release edge 3", ctrl_up, 1'b1);

    // R4 supply drop restarts hold-off
    sup_ok = 1'b0;
    step(3);
    chk("R4 drop edge 3", ctrl_up, 1'b1);
    step(1);
    chk("R4 drop edge 4", ctrl_up, 1'b0);
    chk("R4 drop on", laser_on, 1'b0);
    sup_ok = 1'b1;
    step(HOLD + 2);
    chk("R4 restart before", ctrl_up, 1'b0);
    step(1);
    chk("R4 restart up", ctrl_up, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule